// File: doc/BRIEF.md
# Sound Generator Twin Interval Timers

This block supplies the two programmable interval timers of an FM sound generator and the two sticky status flags they raise. A host writes four small configuration registers through a byte-wide write port: the upper eight bits of the fast timer's reload value, its lower two bits, the slow timer's 8-bit reload value, and a control byte. The block then produces its own tick from the input clock, counts each enabled timer down from its reload value, reloads it on expiry and, if the host has asked for it, sets that timer's flag.

The fast timer steps once every 144 input clocks. The slow timer steps once for every 16 fast-timer steps. The status-read path of the surrounding chip simply samples the two flag bits. Clearing a flag is done by writing the control byte with the matching clear bit set. That bit acts as a one-shot command and is never stored.

Top module: `fmtmr_timers`

## Requirements
- R1: After reset both bits of `flags` are 0.
- R2: The fast timer (timer 0) reload value is 10 bits: register select 0 supplies bits 9..2 and bits 1..0 of register select 1 supply bits 1..0. The upper six bits written to select 1 are ignored. With reload R the timer expires every (R+1)*144 clocks.
- R3: The slow timer (timer 1) takes its 8-bit reload value R from register select 2. It steps once per 16 fast-timer steps and expires every (R+1)*2304 clocks.
- R4: Control byte (register select 3) bit 0 runs timer 0 and bit 1 runs timer 1. A write that turns a run bit from 0 to 1 loads that timer with its reload value, so that the first expiry follows between R*144+1 and (R+1)*144 clocks later for timer 0.
- R5: Control bit 2 (timer 0) and bit 3 (timer 1) allow the expiry to set the flag. `flags` bit 0 belongs to timer 0 and bit 1 to timer 1. When the allow bit is 0 the flag stays 0, but the timer keeps counting and reloading.
- R6: A stopped timer never sets its flag.
- R7: A control write with bit 4 (timer 0) or bit 5 (timer 1) set clears that flag on the following clock edge and leaves the other flag unchanged. The clear bits are not stored, so a later control write without them clears nothing.
- R8: Flags are sticky. Once set, a flag stays 1 when its timer is stopped, until it is cleared by R7 or by reset.
- R9: If an expiry with its allow bit on falls on the same edge as a clear of that flag, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; also the source of the timer tick |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 fast high, 1 fast low, 2 slow, 3 control |
| wr_data | input | 8 | Write data |
| flags | output | 2 | Sticky expiry flags, bit 0 fast timer, bit 1 slow timer |

## Verification
The bench measures exact periods between consecutive flag rises. A wrong prescale ratio, an off-by-one that gives a period of R instead of R+1 ticks, or a swapped 8+2 split of the fast reload value would each shift that count. It also checks that the upper bits of the low register are dropped. It runs a timer with the allow bit off and then turns the bit on without restarting the timer. A design that gated counting with the allow bit would then miss the window for the next rise. It places a clear on exactly the edge where an expiry lands, to catch a design that lets the clear win and loses the event. It also confirms that a clear bit is neither stored nor spills over to the other timer's flag.

// File: rtl/fmtmr_pkg.sv
package fmtmr_pkg;
  localparam int NUM_TMR  = 2;
  localparam int FAST_W   = 10;
  localparam int SLOW_W   = 8;
  localparam int RLD_W    = FAST_W;

  // control byte bit positions (per timer g: base + g)
  localparam int CB_RUN   = 0;
  localparam int CB_ALLOW = 2;
  localparam int CB_CLR   = 4;

  typedef enum logic [1:0] {
    SEL_FAST_HI = 2'd0,
    SEL_FAST_LO = 2'd1,
    SEL_SLOW    = 2'd2,
    SEL_CTRL    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/fmtmr_rst_sync.sv
module fmtmr_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n_out = hold_q;
endmodule

// File: rtl/fmtmr_prescale.sv
module fmtmr_prescale #(
  parameter int TICK_DIV   = 144,
  parameter int SLOW_RATIO = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_fast,
  output logic tick_slow
);
  localparam int PW = (TICK_DIV   > 1) ? $clog2(TICK_DIV)   : 1;
  localparam int SW = (SLOW_RATIO > 1) ? $clog2(SLOW_RATIO) : 1;
  localparam logic [PW-1:0] PRE_LAST  = PW'(TICK_DIV - 1);
  localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_RATIO - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [SW-1:0] sdiv_q, sdiv_d;
  logic          sdiv_en;

  always_comb begin
    tick_fast = (pre_q == PRE_LAST);
    tick_slow = tick_fast && (sdiv_q == SLOW_LAST);
    pre_d     = tick_fast ? '0 : pre_q + 1'b1;
    sdiv_en   = tick_fast;
    sdiv_d    = (sdiv_q == SLOW_LAST) ? '0 : sdiv_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sdiv_q <= '0;
    else if (sdiv_en) sdiv_q <= sdiv_d;
  end

  // R3
  slow_needs_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_slow |-> tick_fast);

  // R2
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= PRE_LAST);

  // R3
  slow_div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_fast |=> $stable(sdiv_q));
endmodule

// File: rtl/fmtmr_down.sv
module fmtmr_down #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  input  logic         start,
  input  logic [W-1:0] reload,
  output logic         expire
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    expire = 1'b0;
    if (start) begin
      cnt_en = 1'b1;
      cnt_d  = reload;
    end else if (run && tick) begin
      cnt_en = 1'b1;
      if (cnt_q == '0) begin
        expire = 1'b1;
        cnt_d  = reload;
      end else begin
        cnt_d  = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R6
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> $stable(cnt_q));

  // R6
  expire_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (run && tick && !start));

  // R4
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == $past(reload)));
endmodule

// File: rtl/fmtmr_timers.sv
module fmtmr_timers
  import fmtmr_pkg::*;
#(
  parameter int TICK_DIV   = 144,
  parameter int SLOW_RATIO = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [1:0] flags
);
  localparam int CTL_KEEP = CB_CLR;

  logic                rst_n_s;
  logic [7:0]          fast_hi_q;
  logic [1:0]          fast_lo_q;
  logic [SLOW_W-1:0]   slow_q;
  logic [CTL_KEEP-1:0] ctl_q;
  logic                wr_fhi, wr_flo, wr_slow, wr_ctl;
  logic                tick_fast, tick_slow;
  logic [NUM_TMR-1:0]  tick_v, run_v, allow_v, start_v, clr_v, exp_v;
  logic [NUM_TMR-1:0]  flag_q, flag_d;
  logic [RLD_W-1:0]    reload_v [NUM_TMR];

  fmtmr_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  fmtmr_prescale #(.TICK_DIV(TICK_DIV), .SLOW_RATIO(SLOW_RATIO)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .tick_fast (tick_fast),
    .tick_slow (tick_slow)
  );

  always_comb begin
    wr_fhi  = 1'b0;
    wr_flo  = 1'b0;
    wr_slow = 1'b0;
    wr_ctl  = 1'b0;
    if (wr_en) begin
      case (reg_sel_e'(wr_addr))
        SEL_FAST_HI: wr_fhi  = 1'b1;
        SEL_FAST_LO: wr_flo  = 1'b1;
        SEL_SLOW:    wr_slow = 1'b1;
        default:     wr_ctl  = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    fast_hi_q <= '0;
    else if (wr_fhi) fast_hi_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    fast_lo_q <= '0;
    else if (wr_flo) fast_lo_q <= wr_data[1:0];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     slow_q <= '0;
    else if (wr_slow) slow_q <= wr_data[SLOW_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    ctl_q <= '0;
    else if (wr_ctl) ctl_q <= wr_data[CTL_KEEP-1:0];
  end

  assign tick_v      = {tick_slow, tick_fast};
  assign reload_v[0] = {fast_hi_q, fast_lo_q};
  assign reload_v[1] = RLD_W'(slow_q);

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    localparam int W = (g == 0) ? FAST_W : SLOW_W;

    assign run_v[g]   = ctl_q[CB_RUN + g];
    assign allow_v[g] = ctl_q[CB_ALLOW + g];
    assign start_v[g] = wr_ctl && wr_data[CB_RUN + g] && !ctl_q[CB_RUN + g];
    assign clr_v[g]   = wr_ctl && wr_data[CB_CLR + g];

    fmtmr_down #(.W(W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .tick   (tick_v[g]),
      .run    (run_v[g]),
      .start  (start_v[g]),
      .reload (reload_v[g][W-1:0]),
      .expire (exp_v[g])
    );

    always_comb begin
      flag_d[g] = flag_q[g];
      if (clr_v[g])                flag_d[g] = 1'b0;
      if (exp_v[g] && allow_v[g])  flag_d[g] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s) flag_q[g] <= 1'b0;
      else          flag_q[g] <= flag_d[g];
    end

    // R5
    flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
      $rose(flag_q[g]) |-> $past(exp_v[g] && allow_v[g]));

    // R7
    flag_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
      $fell(flag_q[g]) |-> $past(clr_v[g]));

    // R9
    set_over_clear_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
      (exp_v[g] && allow_v[g] && clr_v[g]) |=> flag_q[g]);

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
      (flag_q[g] && !clr_v[g]) |=> flag_q[g]);
  end

  assign flags = flag_q;
endmodule

// File: tb/fmtmr_timers_test.sv
module fmtmr_timers_test;
  localparam int TD   = 144;
  localparam int SLOW = TD * 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] flags;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  fmtmr_timers uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .flags   (flags)
  );

  always #4 clk = ~clk;

  always @(posedge clk) cycles <= cycles + 1;

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
    report();
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_flag(input int b, input int limit, output int n);
    n = 0;
    while (!flags[b] && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  // measures the exact distance between two consecutive flag rises
  task automatic period(input int b, input logic [7:0] keep, input int exp, input string req);
    int n;
    wait_flag(b, exp + TD + 10, n);
    check(flags[b] == 1'b1, req, flags[b], 1);
    wr(2'd3, keep | (8'h10 << b));
    check(flags[b] == 1'b0, "R7", flags[b], 0);
    wait_flag(b, exp + 10, n);
    check(n + 1 == exp, req, n + 1, exp);
  endtask

  task automatic t_reset();
    do_reset();
    check(flags == 2'b00, "R1", flags, 0);
  endtask

  task automatic t_first_expiry();
    int n;
    do_reset();
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h02);
    wr(2'd3, 8'h05);
    wait_flag(0, 4 * TD, n);
    check(n >= 2 * TD + 1 && n <= 3 * TD, "R4", n, 3 * TD);
  endtask

  task automatic t_fast_periods();
    do_reset();
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h02);
    wr(2'd3, 8'h05);
    period(0, 8'h05, 3 * TD, "R2");
    do_reset();
    wr(2'd0, 8'h01);
    wr(2'd1, 8'hFD);           // upper bits ignored: reload 5
    wr(2'd3, 8'h05);
    period(0, 8'h05, 6 * TD, "R2");
    do_reset();
    wr(2'd3, 8'h05);           // reload 0
    period(0, 8'h05, TD, "R2");
  endtask

  task automatic t_slow_period();
    do_reset();
    wr(2'd2, 8'h01);
    wr(2'd3, 8'h0A);
    period(1, 8'h0A, 2 * SLOW, "R3");
    check(flags[0] == 1'b0, "R5", flags[0], 0);
  endtask

  task automatic t_allow_off();
    int n;
    do_reset();
    wr(2'd3, 8'h01);
    repeat (600) @(negedge clk);
    check(flags[0] == 1'b0, "R5", flags[0], 0);
    wr(2'd3, 8'h05);           // run bit unchanged: no reload
    wait_flag(0, 200, n);
    check(n <= TD && flags[0], "R5", n, TD);
    wr(2'd3, 8'h04);           // stop, keep allow
    repeat (1000) @(negedge clk);
    check(flags[0] == 1'b1, "R8", flags[0], 1);
  endtask

  task automatic t_stopped();
    do_reset();
    wr(2'd3, 8'h0C);
    repeat (3000) @(negedge clk);
    check(flags == 2'b00, "R6", flags, 0);
  endtask

  task automatic t_clear_bits();
    int n;
    do_reset();
    wr(2'd3, 8'h0F);
    wait_flag(1, 2 * SLOW, n);
    wait_flag(0, 2 * TD, n);
    wr(2'd3, 8'h0C);
    check(flags == 2'b11, "R8", flags, 3);
    wr(2'd3, 8'h1C);
    check(flags == 2'b10, "R7", flags, 2);
    wr(2'd3, 8'h0C);
    repeat (5) @(negedge clk);
    check(flags == 2'b10, "R7", flags, 2);
    wr(2'd3, 8'h2C);
    check(flags == 2'b00, "R7", flags, 0);
  endtask

  task automatic t_collision();
    int n;
    do_reset();
    wr(2'd3, 8'h05);
    wait_flag(0, 2 * TD, n);
    repeat (TD - 1) @(negedge clk);
    wr(2'd3, 8'h15);           // clear lands on the expiry edge
    check(flags[0] == 1'b1, "R9", flags[0], 1);
    repeat (50) @(negedge clk);
    wr(2'd3, 8'h15);           // clear away from an expiry
    check(flags[0] == 1'b0, "R9", flags[0], 0);
  endtask

  initial begin
    t_reset();
    t_first_expiry();
    t_fast_periods();
    t_slow_period();
    t_allow_off();
    t_stopped();
    t_clear_bits();
    t_collision();
    report();
  end
endmodule